// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This unit observes the stream of memory accesses leaving a memory arbiter and compares every access against a small set of independent watchpoints. Each watchpoint holds an inclusive address window, a mask of access kinds (read, write) and a mask of requesting clients. When an access meets all three conditions, the watchpoint records details of the access in capture registers and raises its own status bit. Each status bit is gated by an interrupt mask, and the gated bits are combined into a single interrupt line.

Software programs the windows and masks through a simple word-addressed register port. A hit freezes the capture registers, so the first offending access is preserved. Later hits still add their client to the accumulated client set and keep the status bit set. The capture registers are released by a per-watchpoint acknowledge register. The status bits are cleared separately by a top-level acknowledge register, one bit per watchpoint.

The observation port follows valid/ready rules. `obs_ready` is held high, so the unit never applies back-pressure. An access is sampled on each rising clock edge where `obs_valid` is high. The fields must be stable while `obs_valid` is high. The register port and the interrupt are plain control signals.

Top module: `addr_watch_unit`

## Requirements
- R1: An access sampled with `obs_valid` high hits a watchpoint when three conditions all hold: its address lies in [first, last], its kind bit is set in the kind mask, and bit `obs_client` of the client mask is set. Several watchpoints may hit on the same access.
- R2: Address bounds are inclusive. An address equal to first or last hits. first-1 and last+1 do not.
- R3: Kind mask bit 0 enables reads (`obs_write`=0) and bit 1 enables writes (`obs_write`=1).
- R4: Client mask bit n (n = `obs_client`, 0..15) enables client n. Clear bits block that client.
- R5: The first hit after release loads the capture registers, and they then hold until the watchpoint is released. The capture registers are the address (offset 5) and an info word (offset 6). The info word has bit 0 = write, bits 7:4 = client and bits 10:8 = size. A watchpoint is released by writing 1 to bit 0 of its acknowledge word (offset 7).
- R6: The captured client set (offset 4) is loaded with the one-hot client of the first hit. It then accumulates, by OR, the client of every later hit until the watchpoint is released.
- R7: A hit sets the watchpoint's raw status bit (word 1, bit i for watchpoint i). Writing 1 to bit i of the acknowledge word (word 3) clears it. A hit in the same cycle as the clear wins.
- R8: `irq` is high exactly when some raw status bit is set and its mask bit is set. The mask is word 0, bit i for watchpoint i. Word 2 reads the raw status ANDed with the mask.
- R9: After reset all configuration, capture, status and mask registers read zero, `irq` is low, and no access hits.
- R10: `obs_ready` is always high. Accesses presented with `obs_valid` low cause no hit.
- R11: Watchpoint i has its registers at word base 8*(i+1). The offsets are 0 first, 1 last, 2 kind mask, 3 client mask, and the capture offsets given above. Configuration words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Observed access is present |
| obs_ready | output | 1 | Always high; no back-pressure |
| obs_addr | input | 32 | Access address |
| obs_client | input | 4 | Requesting client number |
| obs_write | input | 1 | 1 = write, 0 = read |
| obs_size | input | 3 | Access size code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Masked interrupt |

## Verification
Three watchpoints are given overlapping windows of very different shapes: a 16-word window open to every client and kind, a single-address window open only to writes from one client, and a wide window open only to reads from another client. A sweep of addresses across both edges of the windows, crossed with both access kinds and three clients, is then compared against arithmetic predictions for each watchpoint. This separates the inclusive bound handling from the kind and client filtering. Further directed sequences cover the following:
- frozen captures against the accumulating client set, across a release;
- masked against unmasked interrupts;
- a hit arriving in the same cycle as a status clear;
- accesses presented without `obs_valid`.

// File: rtl/awu_pkg.sv
package awu_pkg;
  // register offsets inside one watchpoint's 8-word window
  localparam logic [2:0] OFF_FIRST   = 3'd0;
  localparam logic [2:0] OFF_LAST    = 3'd1;
  localparam logic [2:0] OFF_KIND    = 3'd2;
  localparam logic [2:0] OFF_CLIENTS = 3'd3;
  localparam logic [2:0] OFF_CAPCLI  = 3'd4;
  localparam logic [2:0] OFF_CAPADDR = 3'd5;
  localparam logic [2:0] OFF_CAPINFO = 3'd6;
  localparam logic [2:0] OFF_RELEASE = 3'd7;
  // top-level words
  localparam logic [2:0] TOP_MASK    = 3'd0;
  localparam logic [2:0] TOP_RAW     = 3'd1;
  localparam logic [2:0] TOP_MASKED  = 3'd2;
  localparam logic [2:0] TOP_ACK     = 3'd3;
  // info word field positions
  localparam int INFO_CID_LSB  = 4;
  localparam int INFO_SIZE_LSB = 8;
endpackage

// File: rtl/awu_match.sv
module awu_match #(
  parameter int ADDR_W = 32,
  parameter int CID_W  = 4
) (
  input  logic                  acc_valid,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [CID_W-1:0]      acc_cid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     cfg_first,
  input  logic [ADDR_W-1:0]     cfg_last,
  input  logic [1:0]            cfg_kind,
  input  logic [(1<<CID_W)-1:0] cfg_clients,
  output logic                  hit
);
  logic in_window;
  logic kind_ok;
  logic client_ok;

  always_comb begin
    in_window = (acc_addr >= cfg_first) && (acc_addr <= cfg_last);
    kind_ok   = acc_write ? cfg_kind[1] : cfg_kind[0];
    client_ok = cfg_clients[acc_cid];
    hit       = acc_valid && in_window && kind_ok && client_ok;
  end
endmodule

// File: rtl/awu_wp.sv
module awu_wp
  import awu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CID_W  = 4,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_off,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [2:0]         rd_off,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [CID_W-1:0]   acc_cid,
  input  logic               acc_write,
  input  logic [SIZE_W-1:0]  acc_size,
  input  logic               top_ack,
  output logic               status
);
  localparam int NCLI = 1 << CID_W;

  logic [ADDR_W-1:0] cfg_first, cfg_last;
  logic [1:0]        cfg_kind;
  logic [NCLI-1:0]   cfg_clients;
  logic              frozen;
  logic [NCLI-1:0]   cap_clients;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_write;
  logic [CID_W-1:0]  cap_cid;
  logic [SIZE_W-1:0] cap_size;
  logic              hit;
  logic              release_wr;
  logic              load;
  logic [NCLI-1:0]   cid_onehot;
  logic [DATA_W-1:0] info_word;

  awu_match #(.ADDR_W(ADDR_W), .CID_W(CID_W)) u_match (
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_cid    (acc_cid),
    .acc_write  (acc_write),
    .cfg_first  (cfg_first),
    .cfg_last   (cfg_last),
    .cfg_kind   (cfg_kind),
    .cfg_clients(cfg_clients),
    .hit        (hit)
  );

  always_comb begin
    release_wr = cfg_we && (cfg_off == OFF_RELEASE) && cfg_wdata[0];
    load       = hit && (!frozen || release_wr);
    cid_onehot = NCLI'(1) << acc_cid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_first   <= '0;
      cfg_last    <= '0;
      cfg_kind    <= '0;
      cfg_clients <= '0;
    end else if (cfg_we) begin
      case (cfg_off)
        OFF_FIRST:   cfg_first   <= cfg_wdata[ADDR_W-1:0];
        OFF_LAST:    cfg_last    <= cfg_wdata[ADDR_W-1:0];
        OFF_KIND:    cfg_kind    <= cfg_wdata[1:0];
        OFF_CLIENTS: cfg_clients <= cfg_wdata[NCLI-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen      <= 1'b0;
      cap_clients <= '0;
      cap_addr    <= '0;
      cap_write   <= 1'b0;
      cap_cid     <= '0;
      cap_size    <= '0;
      status      <= 1'b0;
    end else begin
      frozen <= hit || (frozen && !release_wr);
      status <= hit || (status && !top_ack);
      if (load) begin
        cap_clients <= cid_onehot;
        cap_addr    <= acc_addr;
        cap_write   <= acc_write;
        cap_cid     <= acc_cid;
        cap_size    <= acc_size;
      end else if (hit) begin
        cap_clients <= cap_clients | cid_onehot;
      end
    end
  end

  always_comb begin
    info_word = '0;
    info_word[0] = cap_write;
    info_word[INFO_CID_LSB +: CID_W] = cap_cid;
    info_word[INFO_SIZE_LSB +: SIZE_W] = cap_size;
    case (rd_off)
      OFF_FIRST:   rd_data = DATA_W'(cfg_first);
      OFF_LAST:    rd_data = DATA_W'(cfg_last);
      OFF_KIND:    rd_data = DATA_W'(cfg_kind);
      OFF_CLIENTS: rd_data = DATA_W'(cfg_clients);
      OFF_CAPCLI:  rd_data = DATA_W'(cap_clients);
      OFF_CAPADDR: rd_data = DATA_W'(cap_addr);
      OFF_CAPINFO: rd_data = info_word;
      default:     rd_data = DATA_W'(frozen);
    endcase
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !release_wr) |=> $stable(cap_addr)); // R5
  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status); // R7
  AST_ACK_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (top_ack && !hit) |=> !status); // R7
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !hit); // R10
  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_addr >= cfg_first && acc_addr <= cfg_last)); // R2
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  parameter int CID_W  = 4,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  localparam int RA_W  = $clog2(8 * (NUM_WP + 1)),
  localparam int SEL_W = RA_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  output logic              obs_ready,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [CID_W-1:0]  obs_client,
  input  logic              obs_write,
  input  logic [SIZE_W-1:0] obs_size,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_WP-1:0] intr_mask;
  logic [NUM_WP-1:0] status;
  logic [NUM_WP-1:0] ack_bits;
  logic [DATA_W-1:0] wp_rdata [NUM_WP];
  logic [SEL_W-1:0]  sel;
  logic [2:0]        off;
  logic              top_sel;

  assign obs_ready = 1'b1;

  always_comb begin
    sel      = reg_addr[RA_W-1:3];
    off      = reg_addr[2:0];
    top_sel  = (sel == '0);
    ack_bits = (reg_wr && top_sel && off == TOP_ACK) ? reg_wdata[NUM_WP-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intr_mask <= '0;
    else if (reg_wr && top_sel && off == TOP_MASK) intr_mask <= reg_wdata[NUM_WP-1:0];
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic hit_sel;
    assign hit_sel = (sel == SEL_W'(i + 1));
    awu_wp #(.ADDR_W(ADDR_W), .CID_W(CID_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_wp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (reg_wr && hit_sel),
      .cfg_off   (off),
      .cfg_wdata (reg_wdata),
      .rd_off    (off),
      .rd_data   (wp_rdata[i]),
      .acc_valid (obs_valid),
      .acc_addr  (obs_addr),
      .acc_cid   (obs_client),
      .acc_write (obs_write),
      .acc_size  (obs_size),
      .top_ack   (ack_bits[i]),
      .status    (status[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (top_sel) begin
      case (off)
        TOP_MASK:   reg_rdata = DATA_W'(intr_mask);
        TOP_RAW:    reg_rdata = DATA_W'(status);
        TOP_MASKED: reg_rdata = DATA_W'(status & intr_mask);
        default:    reg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_WP; i++)
        if (sel == SEL_W'(i + 1)) reg_rdata = wp_rdata[i];
    end
  end

  assign irq = |(status & intr_mask);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (intr_mask != '0)); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0)); // R8
endmodule

// File: tb/addr_watch_unit_tb.sv
module addr_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obs_valid = 1'b0;
  logic        obs_ready;
  logic [31:0] obs_addr = '0;
  logic [3:0]  obs_client = '0;
  logic        obs_write = 1'b0;
  logic [2:0]  obs_size = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  addr_watch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ready(obs_ready),
    .obs_addr(obs_addr), .obs_client(obs_client), .obs_write(obs_write),
    .obs_size(obs_size), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic access(logic [31:0] a, logic [3:0] c, logic w, logic [2:0] s, logic v);
    @(negedge clk);
    obs_valid = v; obs_addr = a; obs_client = c; obs_write = w; obs_size = s;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  function automatic logic [5:0] wa(int wp, int off);
    return 6'(8 * (wp + 1) + off);
  endfunction

  function automatic logic [3:0] predict(logic [31:0] a, logic w, logic [3:0] c);
    logic [3:0] e;
    e[0] = (a >= 32'h100 && a <= 32'h10F);
    e[1] = (a == 32'h108) && w && (c == 4'd5);
    e[2] = (a <= 32'hFFF) && !w && (c == 4'd3);
    e[3] = 1'b0;
    return e;
  endfunction

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 irq", 32'(irq), 0);
    rd(6'd1, rv); check("R9 raw status", rv, 0);
    rd(wa(0, 5), rv); check("R9 cap addr", rv, 0);
    rd(wa(2, 3), rv); check("R9 client mask", rv, 0);
    check("R10 ready", 32'(obs_ready), 1);
    access(32'h0, 4'd0, 1'b0, 3'd0, 1'b1);
    rd(6'd1, rv); check("R9 no hit after reset", rv, 0);

    // configuration
    wr(wa(0, 0), 32'h100); wr(wa(0, 1), 32'h10F); wr(wa(0, 2), 3); wr(wa(0, 3), 32'hFFFF);
    wr(wa(1, 0), 32'h108); wr(wa(1, 1), 32'h108); wr(wa(1, 2), 2); wr(wa(1, 3), 32'h20);
    wr(wa(2, 0), 32'h0);   wr(wa(2, 1), 32'hFFF); wr(wa(2, 2), 1); wr(wa(2, 3), 32'h8);
    rd(wa(1, 3), rv); check("R11 client mask readback", rv, 32'h20);
    rd(wa(2, 1), rv); check("R11 last readback", rv, 32'hFFF);

    // sweep R1 R2 R3 R4 R11
    for (int a = 32'hFC; a <= 32'h113; a++) begin
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < 3; k++) begin
          logic [3:0] c;
          c = (k == 0) ? 4'd3 : (k == 1) ? 4'd5 : 4'd9;
          access(32'(a), c, 1'(w), 3'd1, 1'b1);
          rd(6'd1, rv);
          check("R1 R2 R3 R4 R11 sweep status", rv, 32'(predict(32'(a), 1'(w), c)));
          wr(6'd3, 32'hF);
          rd(6'd1, rv);
          check("R7 status cleared", rv, 0);
        end
      end
    end

    // capture R5 R6
    wr(wa(0, 7), 1);
    access(32'h104, 4'd9, 1'b1, 3'd5, 1'b1);
    access(32'h10A, 4'd3, 1'b0, 3'd2, 1'b1);
    rd(wa(0, 5), rv); check("R5 frozen addr", rv, 32'h104);
    rd(wa(0, 6), rv); check("R5 frozen info", rv, (32'd5 << 8) | (32'd9 << 4) | 32'd1);
    rd(wa(0, 4), rv); check("R6 accumulated clients", rv, (32'd1 << 9) | (32'd1 << 3));
    wr(wa(0, 7), 1);
    access(32'h10C, 4'd5, 1'b0, 3'd7, 1'b1);
    rd(wa(0, 5), rv); check("R5 recapture addr", rv, 32'h10C);
    rd(wa(0, 6), rv); check("R5 recapture info", rv, (32'd7 << 8) | (32'd5 << 4));
    rd(wa(0, 4), rv); check("R6 clients after release", rv, 32'd1 << 5);
    wr(6'd3, 32'hF);

    // interrupt masking R8
    access(32'h100, 4'd1, 1'b0, 3'd0, 1'b1);
    @(negedge clk); check("R8 masked off irq", 32'(irq), 0);
    rd(6'd2, rv); check("R8 masked status zero", rv, 0);
    wr(6'd0, 32'h2);
    @(negedge clk); check("R8 other bit masked irq", 32'(irq), 0);
    wr(6'd0, 32'h1);
    @(negedge clk); check("R8 irq raised", 32'(irq), 1);
    rd(6'd2, rv); check("R8 masked status", rv, 1);
    wr(6'd3, 32'h1);
    @(negedge clk); check("R8 irq after ack", 32'(irq), 0);

    // hit wins over ack R7
    @(negedge clk);
    obs_valid = 1'b1; obs_addr = 32'h101; obs_client = 4'd2; obs_write = 1'b1;
    reg_wr = 1'b1; reg_addr = 6'd3; reg_wdata = 32'hF;
    @(negedge clk);
    obs_valid = 1'b0; reg_wr = 1'b0;
    rd(6'd1, rv); check("R7 hit beats ack", rv, 1);
    wr(6'd3, 32'hF);

    // invalid access R10
    access(32'h105, 4'd3, 1'b0, 3'd0, 1'b0);
    rd(6'd1, rv); check("R10 no valid no hit", rv, 0);
    check("R10 ready held", 32'(obs_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule